// File: doc/BRIEF.md
# Multi-Edge Timestamp Period Meter

This block measures the period of an oscillator that is available as square waves in quadrature. The 0° and 90° squares are combined by XOR so that every oscillator cycle produces four transitions. An optional eight-transition mode additionally XORs in the +45° and -45° squares. Each transition of the combined signal is stamped with a free-running timer. The stamp from N transitions earlier is subtracted from each new stamp, which yields N transition intervals measured in system clocks. A single-stage integrator-comb decimator then adds up R of these differences.

The result is a period sum, R·N·P/E for an oscillator period of P clocks and E transitions per cycle, strobed by a one-cycle valid. The consumer turns this into a frequency or a sensor value. The configuration (transition mode, N, R) is static. Any change to it flushes the stamp history and the decimator, and the measurement starts again.

Top module: `period_meter`

## Requirements
- R1: While rst_ni is low, period_valid_o is 0 and period_sum_o is 0.
- R2: With edge8_i = 0, a transition is every rising and falling change of (0° XOR 90°). For a steady period of P clocks (P a multiple of 4), each result equals R·N·P/4.
- R3: With edge8_i = 1, the combined signal is (0° XOR 90°) XOR (+45° XOR -45°). For a steady period P (a multiple of 8), each result equals R·N·P/8.
- R4: After reset or a flush, no difference is produced until N+1 transitions have been stamped. No result appears within N·P/E clocks of the oscillator starting.
- R5: The timer is TS_W bits wide and wraps freely. Differences are taken modulo 2^TS_W, so results stay correct across timer wrap. Every difference is at least N.
- R6: With edge8_i = 0, the +45° and -45° inputs have no effect on any output.
- R7: N = 2^min(n_sel_i, RING_LOG2), so a code above RING_LOG2 selects the deepest ring. R = 2^r_sel_i. Exactly one result is emitted per R differences, and it is the sum of those R differences.
- R8: A change of edge8_i, n_sel_i or r_sel_i flushes the ring and the decimator. period_valid_o is 0 in the next cycle, and results reflect only transitions seen after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; timer base |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sq_0_i | input | 1 | 0° square, asynchronous |
| sq_90_i | input | 1 | 90° square, asynchronous |
| sq_p45_i | input | 1 | +45° square, asynchronous |
| sq_m45_i | input | 1 | -45° square, asynchronous |
| edge8_i | input | 1 | 0: four transitions per cycle, 1: eight |
| n_sel_i | input | NSEL_W (3) | log2 of the delay length N |
| r_sel_i | input | RSEL_W (3) | log2 of the decimation R |
| period_valid_o | output | 1 | One-cycle strobe for a new result |
| period_sum_o | output | TS_W+2^RSEL_W-1 (23) | Sum of R N-transition intervals, in clocks |

## Verification
Some properties are checked on every cycle. No difference leaves the ring before N+1 transitions have been counted since the last flush, and every difference is at least N. The decimator fires only after exactly R differences. A configuration change forces the valid low in the following cycle. In four-transition mode, unchanged 0° and 90° samples produce no transition, whatever the diagonal inputs do. The bench scenarios are needed for the rest. They show that the absolute sums equal R·N·P/E in both modes, and that a timer wrap during a long run leaves every result intact. They also show that after a flush, the results match the new mode.

// File: rtl/pme_pkg.sv
package pme_pkg;
  typedef enum logic {
    EDGE_X4 = 1'b0,
    EDGE_X8 = 1'b1
  } edge_mode_e;

  localparam int LANES   = 4;
  localparam int LANE_0  = 0;
  localparam int LANE_90 = 1;
  localparam int LANE_P45 = 2;
  localparam int LANE_M45 = 3;
endpackage

// File: rtl/pme_edge_front.sv
module pme_edge_front
  import pme_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] sq_i,
  input  edge_mode_e       mode_i,
  output logic             edge_o
);
  logic [LANES-1:0] synced;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[SYNC_STAGES-2:0], sq_i[l]};
    end
    assign synced[l] = chain_q[SYNC_STAGES-1];
  end

  logic diag_x, comb_x, lvl_q, prev_q;
  assign diag_x = (mode_i == EDGE_X8) ? (synced[LANE_P45] ^ synced[LANE_M45]) : 1'b0;
  assign comb_x = synced[LANE_0] ^ synced[LANE_90] ^ diag_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= comb_x;
      prev_q <= lvl_q;
    end
  end

  assign edge_o = lvl_q ^ prev_q;

  AST_X4_DIAG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EDGE_X4 && $past(mode_i) == EDGE_X4 &&
     $stable(synced[LANE_0]) && $stable(synced[LANE_90])) |=> !edge_o); // R6
endmodule

// File: rtl/pme_stamp_ring.sv
module pme_stamp_ring #(
  parameter int TS_W      = 16,
  parameter int RING_LOG2 = 6,
  parameter int NSEL_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              edge_i,
  input  logic [NSEL_W-1:0] n_sel_i,
  output logic              diff_valid_o,
  output logic [TS_W-1:0]   diff_o
);
  localparam int DEPTH = 1 << RING_LOG2;

  logic [TS_W-1:0]      timer_q;
  logic [TS_W-1:0]      ring_q [DEPTH];
  logic [RING_LOG2-1:0] wp_q, mask;
  logic [RING_LOG2:0]   fill_q, n_size;
  logic [NSEL_W-1:0]    n_log;
  logic                 full, dv_q;
  logic [TS_W-1:0]      diff_q;

  assign n_log  = (n_sel_i > NSEL_W'(RING_LOG2)) ? NSEL_W'(RING_LOG2) : n_sel_i;
  assign n_size = {{RING_LOG2{1'b0}}, 1'b1} << n_log;
  assign mask   = RING_LOG2'(n_size - 1'b1);
  assign full   = (fill_q == n_size);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_q <= '0;
    else         timer_q <= timer_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (edge_i && !clear_i) ring_q[wp_q] <= timer_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      fill_q <= '0;
      dv_q   <= 1'b0;
      diff_q <= '0;
    end else if (clear_i) begin
      wp_q   <= '0;
      fill_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      dv_q <= edge_i && full;
      if (edge_i) begin
        diff_q <= timer_q - ring_q[wp_q];  // modular: survives timer wrap
        wp_q   <= (wp_q + 1'b1) & mask;
        if (!full) fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign diff_valid_o = dv_q;
  assign diff_o       = diff_q;

  // independent edge tally for the fill check
  logic [7:0] chk_edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             chk_edges_q <= '0;
    else if (clear_i)        chk_edges_q <= '0;
    else if (edge_i && chk_edges_q != 8'hff) chk_edges_q <= chk_edges_q + 1'b1;
  end

  AST_NO_EARLY_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diff_valid_o && !clear_i) |-> (chk_edges_q > 8'(n_size))); // R4
  AST_DIFF_AT_LEAST_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diff_valid_o && !clear_i) |-> (diff_o >= TS_W'(n_size))); // R5
endmodule

// File: rtl/pme_cic.sv
module pme_cic #(
  parameter int IN_W   = 16,
  parameter int RSEL_W = 3,
  localparam int RMAX_LOG2 = (1 << RSEL_W) - 1,
  localparam int OW        = IN_W + RMAX_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              din_valid_i,
  input  logic [IN_W-1:0]   din_i,
  input  logic [RSEL_W-1:0] r_sel_i,
  output logic              valid_o,
  output logic [OW-1:0]     sum_o
);
  logic [RMAX_LOG2-1:0] cnt_q, r_last;
  logic [OW-1:0]        integ_q, comb_q, sum_q, integ_nx;
  logic                 valid_q;

  assign r_last   = RMAX_LOG2'((32'd1 << r_sel_i) - 32'd1);
  assign integ_nx = integ_q + OW'(din_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      comb_q  <= '0;
      sum_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (clear_i) begin
      integ_q <= '0;
      comb_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (din_valid_i) begin
        integ_q <= integ_nx;
        if (cnt_q == r_last) begin
          cnt_q   <= '0;
          comb_q  <= integ_nx;
          sum_q   <= integ_nx - comb_q;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign sum_o   = sum_q;

  logic [RMAX_LOG2:0] chk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_q <= '0;
    else if (clear_i) chk_q <= '0;
    else              chk_q <= (valid_q ? '0 : chk_q) + {{RMAX_LOG2{1'b0}}, din_valid_i};
  end

  AST_ONE_PER_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clear_i) |-> (chk_q == (RMAX_LOG2 + 1)'(r_last) + 1'b1)); // R7
endmodule

// File: rtl/period_meter.sv
module period_meter
  import pme_pkg::*;
#(
  parameter int TS_W        = 16,
  parameter int RING_LOG2   = 6,
  parameter int NSEL_W      = 3,
  parameter int RSEL_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SUM_W      = TS_W + (1 << RSEL_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sq_0_i,
  input  logic              sq_90_i,
  input  logic              sq_p45_i,
  input  logic              sq_m45_i,
  input  logic              edge8_i,
  input  logic [NSEL_W-1:0] n_sel_i,
  input  logic [RSEL_W-1:0] r_sel_i,
  output logic              period_valid_o,
  output logic [SUM_W-1:0]  period_sum_o
);
  localparam int CFG_W = 1 + NSEL_W + RSEL_W;

  logic [CFG_W-1:0] cfg, cfg_q;
  logic             clear, edge_det, diff_valid;
  logic [TS_W-1:0]  diff;
  logic [LANES-1:0] sq_vec;
  edge_mode_e       mode;

  assign cfg   = {edge8_i, n_sel_i, r_sel_i};
  assign clear = (cfg != cfg_q);
  assign mode  = edge8_i ? EDGE_X8 : EDGE_X4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg;
  end

  always_comb begin
    sq_vec           = '0;
    sq_vec[LANE_0]   = sq_0_i;
    sq_vec[LANE_90]  = sq_90_i;
    sq_vec[LANE_P45] = sq_p45_i;
    sq_vec[LANE_M45] = sq_m45_i;
  end

  pme_edge_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sq_i  (sq_vec),
    .mode_i(mode),
    .edge_o(edge_det)
  );

  pme_stamp_ring #(.TS_W(TS_W), .RING_LOG2(RING_LOG2), .NSEL_W(NSEL_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .edge_i      (edge_det),
    .n_sel_i     (n_sel_i),
    .diff_valid_o(diff_valid),
    .diff_o      (diff)
  );

  pme_cic #(.IN_W(TS_W), .RSEL_W(RSEL_W)) u_cic (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .din_valid_i(diff_valid),
    .din_i      (diff),
    .r_sel_i    (r_sel_i),
    .valid_o    (period_valid_o),
    .sum_o      (period_sum_o)
  );

  AST_CFG_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({edge8_i, n_sel_i, r_sel_i} != $past({edge8_i, n_sel_i, r_sel_i})) |=> !period_valid_o); // R8
endmodule

// File: tb/sim_period_meter.sv
`timescale 1ns/1ps
module sim_period_meter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sq0 = 0, sq90 = 0, sqp = 0, sqm = 0, edge8 = 0;
  logic [2:0]  nsel = 0, rsel = 0;
  logic        pv;
  logic [22:0] psum;

  int n_chk = 0, n_fail = 0;
  int per = 32, t = 0;
  bit done = 0;

  always #4 clk = ~clk;

  period_meter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sq_0_i(sq0), .sq_90_i(sq90),
    .sq_p45_i(sqp), .sq_m45_i(sqm), .edge8_i(edge8),
    .n_sel_i(nsel), .r_sel_i(rsel),
    .period_valid_o(pv), .period_sum_o(psum)
  );

  function automatic int n_of(int s); return 1 << ((s > 6) ? 6 : s); endfunction
  function automatic int exp_sum(int r_s, int n_s, int p, int e);
    return (1 << r_s) * n_of(n_s) * (p / e);
  endfunction
  function automatic bit level(int tt, int off);
    return ((tt + off) % per) < (per / 2);
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic drive_step();
    sq0  = level(t, 0);
    sq90 = level(t, per / 4);
    if (edge8) begin
      sqp = level(t, per / 8);
      sqm = level(t, 7 * per / 8);
    end else begin
      sqp = 1'($urandom);   // R6: junk on diagonals
      sqm = 1'($urandom);
    end
    t = (t + 1) % per;
  endtask

  task automatic do_reset(bit m, int ns, int rs, int p);
    @(negedge clk);
    rst_ni = 0; sq0 = 0; sq90 = 0; sqp = 0; sqm = 0;
    edge8 = m; nsel = 3'(ns); rsel = 3'(rs); per = p; t = 0;
    repeat (3) @(negedge clk);
    check(pv == 1'b0, "R1 valid", pv, 0);
    check(psum == '0, "R1 sum", psum, 0);
    rst_ni = 1;
  endtask

  task automatic run_outputs(int nout, int skip, int expv, string req, int limit,
                             output int first_cyc);
    int got = 0, seen = 0, cyc = 0;
    first_cyc = -1;
    while (got < nout && cyc < limit) begin
      @(negedge clk);
      if (pv) begin
        if (first_cyc < 0) first_cyc = cyc;
        seen++;
        if (seen > skip) begin
          got++;
          check(psum == 23'(expv), req, psum, expv);
        end
      end
      cyc++;
      drive_step();
    end
    if (got < nout) check(1'b0, {req, " missing result"}, got, nout);
  endtask

  task automatic trial(bit m, int ns, int rs, int p, string req);
    int e = m ? 8 : 4;
    int fc;
    do_reset(m, ns, rs, p);
    run_outputs(3, 0, exp_sum(rs, ns, p, e), req,
                (n_of(ns) + (1 << rs) * 4) * p + 200, fc);
    check(fc >= n_of(ns) * (p / e), "R4 early result", fc, n_of(ns) * (p / e));
  endtask

  initial begin
    int fc, cnt;
    void'($urandom(32'h1a2b));
    // directed
    trial(0, 2, 1, 32, "R2 x4");
    trial(1, 3, 0, 64, "R3 x8");
    trial(0, 0, 0, 16, "R7 N=1");
    trial(1, 7, 0, 16, "R7 clamp");
    trial(0, 5, 3, 48, "R7 R=8");
    // random
    for (int i = 0; i < 16; i++) begin
      bit m = 1'($urandom);
      int ns = int'($urandom % 8);
      int rs = int'($urandom % 4);
      int p = 16 + 8 * int'($urandom % 11);
      trial(m, ns, rs, p, m ? "R3 rand" : "R2 R6 rand");
    end
    // flush on config change
    do_reset(0, 4, 0, 32);
    run_outputs(3, 0, exp_sum(0, 4, 32, 4), "R2 pre-flush", 2000, fc);
    edge8 = 1;
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pv) cnt++;
      drive_step();
    end
    check(cnt == 0, "R8 no result while refilling", cnt, 0);
    run_outputs(3, 2, exp_sum(0, 4, 32, 8), "R8 post-flush", 2000, fc);
    // long run across timer wrap
    do_reset(0, 6, 3, 96);
    run_outputs(360, 0, exp_sum(3, 6, 96, 4), "R5 wrap", 75000, fc);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule